// File: doc/BRIEF.md
# Slave-Clocked Serial Byte Transmitter

This block is the transmit side of a serial port whose bit clock comes from an external master. A host loads one byte at a time into a single-entry holding register and sets a run bit. The external serial clock is brought into the system clock domain by a flop chain, and an edge detector turns it into one-cycle falling and rising strobes. Each byte leaves on the data pin most significant bit first. The data pin changes on serial clock falling edges, so the master can sample it on rising edges. While the run bit stays set, bytes follow each other with no idle clock between them.

The holding register hands its byte to the shifter on the first falling edge of each byte. At that moment it reports itself empty and pulses an interrupt, so the host can write the next byte. If a byte has to start while the holding register is still empty, the block enters an underrun error. It parks the data pin high, raises an error flag, and pulses the interrupt on the following serial falling edge. It stays in that state until the host issues a force-stop. Force-stop clears the run bit, the holding register and every flag. If the host clears the run bit during a byte, the current byte completes, and the last bit is held for a short, bounded time before the pin returns high.

Top module: `sst_slave_tx`

## Requirements
- R1: After reset, `sdo` is 1, `buf_empty` is 1, and `busy`, `tx_err`, `irq` and `start_bit` are 0.
- R2: Each byte is driven on `sdo` most significant bit first. A new bit appears on `sdo` within 3 system clocks after each serial clock falling edge, so it is stable at the following rising edge.
- R3: While `start_bit` is 1 and the host refills the holding register during the current byte, the next byte's bit 7 follows the previous byte's bit 0 on the very next serial falling edge.
- R4: When a byte moves from the holding register into the shifter, `buf_empty` goes to 1 and `irq` pulses high for exactly one system clock. A host write while `buf_empty` is 1 stores the byte and drops `buf_empty` to 0 on the next clock.
- R5: A host write while `buf_empty` is 0 is ignored: the byte already held is the one transmitted next.
- R6: If a byte must start while the holding register is empty, `tx_err` goes to 1 and `busy` goes to 0 within 3 clocks of that serial falling edge, with no `irq` at that time. `irq` pulses once after the next serial falling edge.
- R7: Setting the run bit with nothing ever written, then giving a serial falling edge, raises `tx_err` in the same way as R6.
- R8: While `tx_err` is 1, `sdo` stays 1 and `tx_err` stays set, regardless of serial clock edges or host writes, until a force-stop.
- R9: A force-stop pulse brings `start_bit`, `tx_err` and `busy` to 0, `buf_empty` to 1 and `sdo` to 1 on the next clock, and discards any held byte.
- R10: If the run bit is cleared during a byte, that byte completes. After its last serial rising edge, `sdo` keeps bit 0 and `busy` stays 1 for at least 4 system clocks. Within 8 system clocks `sdo` returns to 1 and `busy` drops to 0.
- R11: While `start_bit` is 0, serial clock edges start nothing: `sdo` stays 1, `busy` stays 0 and a held byte stays held (`buf_empty` 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_in | input | 1 | External serial clock, asynchronous to `clk` |
| host_wr | input | 1 | One-cycle write strobe for the holding register |
| host_wdata | input | 8 | Byte to write |
| start_set | input | 1 | One-cycle pulse that sets the run bit |
| start_clr | input | 1 | One-cycle pulse that clears the run bit (wins over `start_set`) |
| force_stop | input | 1 | One-cycle pulse that aborts and clears the block |
| sdo | output | 1 | Serial data out, idles high |
| buf_empty | output | 1 | Holding register can take a byte |
| busy | output | 1 | A byte is being shifted or held at its end |
| tx_err | output | 1 | Underrun error, sticky until force-stop |
| irq | output | 1 | One-cycle interrupt pulse |
| start_bit | output | 1 | Current run bit |

## Verification
A corrupted bit counter or shift register shows up on `sdo` as a wrong bit at the very next serial rising edge. It can also show as a byte boundary that starts one edge early or late, which breaks the bit order of the following byte within eight serial periods. A lost holding-register state shows up as a spurious underrun (`tx_err`) on the next byte boundary, or as the wrong byte being sent after a rejected write. A wrong end-of-byte decision shows up within eight system clocks of the last rising edge, as `busy` and `sdo` releasing too early or never.

// File: rtl/sst_pkg.sv
// Package: shared types of the slave-clocked serial transmitter.
// Assumes: nothing beyond SystemVerilog 2017.
package sst_pkg;

    // Controller states for the transmit sequencer
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // run bit low or waiting for the first falling edge
        ST_SHIFT = 3'd1,   // bits of a byte are on the pin
        ST_GAP   = 3'd2,   // byte done, run bit set, waiting for next falling edge
        ST_HOLD  = 3'd3,   // run bit cleared, last bit held before release
        ST_ERR   = 3'd4    // underrun, pin parked high until force-stop
    } sst_state_e;

endpackage

// File: rtl/sst_edge_sync.sv
// Module: sst_edge_sync
// Brings an asynchronous serial clock into the system clock domain through
// SYNC_STAGES flops and produces one-cycle strobes for its falling and rising
// edges. Assumes the serial clock half period is longer than SYNC_STAGES+1
// system clocks.
module sst_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic fall_stb,
    output logic rise_stb
);

    // Chain: index 0..SYNC_STAGES-1 are synchronizer flops, last is history
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the serial clock level through the synchronizer and history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], sclk_in};
        end
    end

    // Compare the synchronized level with its previous value
    always_comb begin
        fall_stb = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];
        rise_stb = ~chain_q[CHAIN-1] & chain_q[CHAIN-2];
    end

endmodule

// File: rtl/sst_tx_buffer.sv
// Module: sst_tx_buffer
// Single-entry holding register between the host and the shifter. A host write
// is taken only when empty; a load into the shifter empties it; clear_i wipes
// it. Assumes load_i is only asserted while the register is full.
module sst_tx_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              load_i,
    output logic [DATA_W-1:0] data_o,
    output logic              empty_o
);

    logic [DATA_W-1:0] data_q;
    logic              empty_q;

    // Hold one byte; accept writes only when empty, empty on load or clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            data_q  <= '0;
            empty_q <= 1'b1;
        end else if (load_i) begin
            empty_q <= 1'b1;
        end else if (wr_i && empty_q) begin
            data_q  <= wdata_i;
            empty_q <= 1'b0;
        end
    end

    assign data_o  = data_q;
    assign empty_o = empty_q;

endmodule

// File: rtl/sst_shift_ctrl.sv
// Module: sst_shift_ctrl
// Transmit sequencer and shift register. Starts a byte on a serial falling
// edge when the run bit is set, shifts on later falling edges, counts rising
// edges to find the end of a byte, detects underrun, holds the last bit after
// a stop and raises interrupt pulses. Assumes fall_i and rise_i are never high
// together and that HOLD_CYCLES exceeds SYNC_STAGES + 1.
module sst_shift_ctrl
    import sst_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic              fall_i,
    input  logic              rise_i,
    input  logic              run_i,
    input  logic              buf_full_i,
    input  logic [DATA_W-1:0] buf_data_i,
    output logic              load_o,
    output logic              sdo_o,
    output logic              busy_o,
    output logic              err_o,
    output logic              irq_o
);

    // Rising-edge counter width and hold counter length after synchronizer delay
    localparam int CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int HOLD_CNT = HOLD_CYCLES - SYNC_STAGES - 1;
    localparam int HOLD_W   = (HOLD_CNT > 1) ? $clog2(HOLD_CNT) : 1;
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(DATA_W - 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CNT - 1);

    sst_state_e        state_q;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [HOLD_W-1:0] holdcnt_q;
    logic              err_q;
    logic              err_irq_pend_q;
    logic              irq_q;
    logic              byte_start;
    logic              underrun;

    // A byte boundary: falling edge while running and not mid-byte
    always_comb begin
        byte_start = fall_i && run_i && (state_q == ST_IDLE || state_q == ST_GAP);
        load_o     = byte_start && buf_full_i;
        underrun   = byte_start && !buf_full_i;
    end

    // Sequencer: state, shift register, bit and hold counters, error flag
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i) begin
            state_q        <= ST_IDLE;
            shreg_q        <= '1;
            bitcnt_q       <= '0;
            holdcnt_q      <= '0;
            err_q          <= 1'b0;
            err_irq_pend_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE, ST_GAP: begin
                    if (load_o) begin
                        shreg_q  <= buf_data_i;
                        bitcnt_q <= '0;
                        state_q  <= ST_SHIFT;
                    end else if (underrun) begin
                        err_q          <= 1'b1;
                        err_irq_pend_q <= 1'b1;
                        state_q        <= ST_ERR;
                    end else if (state_q == ST_GAP && !run_i) begin
                        holdcnt_q <= '0;
                        state_q   <= ST_HOLD;
                    end
                end
                ST_SHIFT: begin
                    if (fall_i) begin
                        shreg_q <= {shreg_q[DATA_W-2:0], 1'b1};
                    end
                    if (rise_i) begin
                        if (bitcnt_q == LAST_BIT) begin
                            holdcnt_q <= '0;
                            state_q   <= run_i ? ST_GAP : ST_HOLD;
                        end else begin
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (holdcnt_q == HOLD_LAST) begin
                        state_q <= ST_IDLE;
                    end else begin
                        holdcnt_q <= holdcnt_q + 1'b1;
                    end
                end
                ST_ERR: begin
                    if (fall_i) begin
                        err_irq_pend_q <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Interrupt pulse: on every load, and on the falling edge after an underrun
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= load_o || (state_q == ST_ERR && fall_i && err_irq_pend_q);
        end
    end

    // Output decode: pin shows the shifter MSB only while a byte is active
    always_comb begin
        busy_o = (state_q == ST_SHIFT) || (state_q == ST_GAP) || (state_q == ST_HOLD);
        sdo_o  = busy_o ? shreg_q[DATA_W-1] : 1'b1;
        err_o  = err_q;
        irq_o  = irq_q;
    end

endmodule

// File: rtl/sst_slave_tx.sv
// Module: sst_slave_tx (top)
// Serial byte transmitter slaved to an external serial clock. Holds the run
// bit and wires the synchronizer, holding register and sequencer together.
// Assumes host strobes are one system clock wide and synchronous to clk.
module sst_slave_tx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              start_set,
    input  logic              start_clr,
    input  logic              force_stop,
    output logic              sdo,
    output logic              buf_empty,
    output logic              busy,
    output logic              tx_err,
    output logic              irq,
    output logic              start_bit
);

    logic              run_q;
    logic              fall_stb;
    logic              rise_stb;
    logic              load;
    logic [DATA_W-1:0] buf_data;
    logic              buf_empty_w;

    // Run bit: force-stop and clear win over set
    always_ff @(posedge clk) begin
        if (!rst_n || force_stop) begin
            run_q <= 1'b0;
        end else if (start_clr) begin
            run_q <= 1'b0;
        end else if (start_set) begin
            run_q <= 1'b1;
        end
    end

    sst_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_in  (sclk_in),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    sst_tx_buffer #(
        .DATA_W(DATA_W)
    ) buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (force_stop),
        .wr_i    (host_wr),
        .wdata_i (host_wdata),
        .load_i  (load),
        .data_o  (buf_data),
        .empty_o (buf_empty_w)
    );

    sst_shift_ctrl #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_i    (force_stop),
        .fall_i     (fall_stb),
        .rise_i     (rise_stb),
        .run_i      (run_q),
        .buf_full_i (!buf_empty_w),
        .buf_data_i (buf_data),
        .load_o     (load),
        .sdo_o      (sdo),
        .busy_o     (busy),
        .err_o      (tx_err),
        .irq_o      (irq)
    );

    assign buf_empty = buf_empty_w;
    assign start_bit = run_q;

endmodule

// File: rtl/sst_slave_tx_chk.sv
// Module: sst_slave_tx_chk
// Port-level protocol checks for sst_slave_tx, bound to every instance.
// Assumes synchronous active-low reset.
module sst_slave_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic host_wr,
    input logic force_stop,
    input logic sdo,
    input logic buf_empty,
    input logic busy,
    input logic tx_err,
    input logic irq,
    input logic start_bit
);

    AST_ERR_PARKS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> sdo); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err && !force_stop) |=> tx_err); // R8
    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> !busy); // R6
    AST_ERR_IRQ_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_err) |-> !irq); // R6
    AST_FSTOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        force_stop |=> (!tx_err && buf_empty && !busy && !start_bit && sdo)); // R9
    AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && buf_empty && !force_stop) |=> !buf_empty); // R4
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R4
    AST_EMPTY_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> (irq || $past(force_stop))); // R4
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sdo); // R11

endmodule

bind sst_slave_tx sst_slave_tx_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .force_stop (force_stop),
    .sdo        (sdo),
    .buf_empty  (buf_empty),
    .busy       (busy),
    .tx_err     (tx_err),
    .irq        (irq),
    .start_bit  (start_bit)
);

// File: tb/sst_slave_tx_tb_top.sv
// Bench for sst_slave_tx: directed corner cases plus seeded random byte streams.
module sst_slave_tx_tb_top;

    localparam int H = 8;   // serial clock half period in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_in = 1'b1;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       start_set = 1'b0;
    logic       start_clr = 1'b0;
    logic       force_stop = 1'b0;
    logic       sdo, buf_empty, busy, tx_err, irq, start_bit;

    int n_checks = 0;
    int n_fail   = 0;
    int irq_cnt  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sst_slave_tx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_in    (sclk_in),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .start_set  (start_set),
        .start_clr  (start_clr),
        .force_stop (force_stop),
        .sdo        (sdo),
        .buf_empty  (buf_empty),
        .busy       (busy),
        .tx_err     (tx_err),
        .irq        (irq),
        .start_bit  (start_bit)
    );

    // Count interrupt pulses
    always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] d);
        host_wr = 1'b1; host_wdata = d;
        wait_n(1);
        host_wr = 1'b0;
    endtask

    task automatic pulse_start();  start_set = 1'b1;  wait_n(1); start_set = 1'b0;  endtask
    task automatic pulse_clr();    start_clr = 1'b1;  wait_n(1); start_clr = 1'b0;  endtask
    task automatic pulse_fstop();  force_stop = 1'b1; wait_n(1); force_stop = 1'b0; endtask

    function automatic bit exp_bit(input logic [7:0] b, input int i);
        return b[7-i];   // MSB first
    endfunction

    // Clock one byte out and check every bit; optional refill, stop and hold check
    task automatic run_byte(input logic [7:0] b, input bit refill, input logic [7:0] nxt,
                            input bit stop_mid);
        int irq0 = irq_cnt;
        for (int i = 0; i < 8; i++) begin
            sclk_in = 1'b0;
            wait_n(H);
            chk(sdo == exp_bit(b, i), "R2 bit", int'(sdo), int'(exp_bit(b, i)));
            if (i == 0) begin
                chk(buf_empty == 1'b1, "R4 empty on load", int'(buf_empty), 1);
                chk(irq_cnt == irq0 + 1, "R4 irq on load", irq_cnt, irq0 + 1);
            end
            if (i == 1 && refill) begin
                host_write(nxt);
                chk(buf_empty == 1'b0, "R4 write fills", int'(buf_empty), 0);
            end
            if (i == 3 && stop_mid) pulse_clr();
            sclk_in = 1'b1;
            if (stop_mid && i == 7) begin
                wait_n(4);
                chk(sdo == b[0] && busy, "R10 hold last bit", {30'd0, busy, sdo}, {30'd0, 1'b1, b[0]});
                wait_n(3);
                chk(sdo && !busy, "R10 release", {30'd0, busy, sdo}, 1);
                wait_n(H - 7);
            end else begin
                wait_n(H);
            end
        end
    endtask

    initial begin
        logic [7:0] cur, nxt;
        int seed_v;
        int irq0;
        seed_v = int'($urandom(32'd5171));

        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        chk(sdo && buf_empty && !busy && !tx_err && !irq && !start_bit, "R1 reset",
            {26'd0, start_bit, irq, tx_err, busy, buf_empty, sdo}, 3);

        // R11: held byte, clock running, run bit low
        host_write(8'hA5);
        for (int k = 0; k < 2; k++) begin
            sclk_in = 1'b0; wait_n(H); sclk_in = 1'b1; wait_n(H);
        end
        chk(sdo && !busy && !buf_empty, "R11 no shift when stopped",
            {29'd0, buf_empty, busy, sdo}, 1);

        // R2/R3/R4: continuous stream, first directed then random
        pulse_start();
        nxt = 8'h5A;
        run_byte(8'hA5, 1'b1, nxt, 1'b0);
        cur = nxt;
        for (int k = 0; k < 10; k++) begin
            nxt = 8'($urandom);
            run_byte(cur, 1'b1, nxt, 1'b0);   // R3 back-to-back bytes
            cur = nxt;
        end
        run_byte(cur, 1'b0, 8'h00, 1'b1);     // R10 stop mid-byte
        chk(!tx_err && !start_bit, "R10 no error after stop", int'(tx_err), 0);

        // R5: second write while full is dropped
        host_write(8'h3C);
        host_write(8'hC3);
        pulse_start();
        run_byte(8'h3C, 1'b0, 8'h00, 1'b0);

        // R6: underrun at the next byte boundary
        irq0 = irq_cnt;
        sclk_in = 1'b0;
        wait_n(4);
        chk(tx_err && sdo && !busy, "R6 underrun flag", {29'd0, busy, sdo, tx_err}, 3);
        chk(irq_cnt == irq0, "R6 no irq yet", irq_cnt, irq0);
        wait_n(H - 4);
        sclk_in = 1'b1; wait_n(H);
        sclk_in = 1'b0; wait_n(4);
        chk(irq_cnt == irq0 + 1, "R6 deferred irq", irq_cnt, irq0 + 1);
        wait_n(H - 4);

        // R8: pin parked high through writes and clocks
        host_write(8'h00);
        for (int k = 0; k < 3; k++) begin
            sclk_in = 1'b1; wait_n(H); sclk_in = 1'b0; wait_n(H);
            chk(sdo && tx_err, "R8 parked high", {30'd0, tx_err, sdo}, 3);
        end
        chk(irq_cnt == irq0 + 1, "R8 no further irq", irq_cnt, irq0 + 1);
        sclk_in = 1'b1; wait_n(H);

        // R9: force-stop clears everything including the held byte
        pulse_fstop();
        chk(!tx_err && buf_empty && !busy && sdo && !start_bit, "R9 force stop",
            {27'd0, start_bit, sdo, busy, buf_empty, tx_err}, 10);

        // R7: run bit set with nothing written
        pulse_start();
        sclk_in = 1'b0; wait_n(H);
        chk(tx_err && sdo, "R7 empty start error", {30'd0, sdo, tx_err}, 3);
        sclk_in = 1'b1; wait_n(H);
        pulse_fstop();
        chk(!tx_err, "R9 error cleared", int'(tx_err), 0);

        // Random stream after recovery
        cur = 8'($urandom);
        host_write(cur);
        pulse_start();
        for (int k = 0; k < 6; k++) begin
            nxt = 8'($urandom);
            run_byte(cur, 1'b1, nxt, 1'b0);   // R2 R3 random patterns
            cur = nxt;
        end
        run_byte(cur, 1'b0, 8'h00, 1'b1);
        chk(buf_empty && !tx_err, "R4 stream drained", {30'd0, tx_err, buf_empty}, 1);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule